// File: doc/BRIEF.md
# Framed Configuration Byte Streamer

This block loads a programmable target device through its byte-wide configuration port. A single start strobe sends the load through five phases in turn. First the block pulls the active-low program line low for a set number of clocks and then releases it. Next it waits for the target's active-low init line to read high. It then writes a fixed eight-byte lead-in. After that it writes one 28-byte frame for each group of 21 payload bytes drawn from a ready/valid source. Last, it writes four startup bytes.

Every byte appears on the data bus for one clock, together with a single-cycle write strobe. A configurable number of idle clocks separates consecutive strobes, so a slow target port meets its write cycle time. Before each frame the block checks the target's status lines. It stops framing at once if init has dropped or done has risen. When the load ends it reports success or failure on sticky flags, which stay set until the next start.

Top module: `fpga_cfg_streamer`

## Requirements
- R1: After reset, prog_n is 1, wr_stb is 0, and busy, done and error are all 0.
- R2: A start pulse received while idle drives prog_n to 0 for exactly HOLD_CLKS clock cycles, then drives it back to 1.
- R3: No write strobe occurs while prog_n is 0, nor after prog_n is released until init_n has been seen high.
- R4: The first eight bytes written are, in order: 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R5: Each frame is 28 bytes long. It holds 0x4F, then 21 payload bytes in the order they arrive, then 0x4B, then 0xFF, 0x4B, 0xFF, 0xFF, 0xFF. A payload byte is written on the clock after its ready/valid handshake.
- R6: When pay_len is not a multiple of 21, the payload positions of the last frame that have no payload byte are written as 0xFF, and no handshake occurs for them.
- R7: A frame starts only while init_n is 1, done_i is 0 and payload bytes remain. At the frame boundary where this condition fails, the block goes straight to the startup bytes.
- R8: The load always ends with exactly four 0xFF startup bytes.
- R9: At the end of a load, done is set if done_i is 1 and every payload byte was sent. Otherwise error is set. The two flags are never set together.
- R10: If init_n stays 0 for INIT_TIMEOUT cycles after prog_n is released, error is set and the block returns to idle without writing any byte.
- R11: Consecutive strobes within a load are separated by exactly gap_clks idle cycles, using the value sampled at start, provided payload is valid when needed.
- R12: A start pulse received while busy has no effect on prog_n or on the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (honoured only while idle) |
| pay_len | input | LEN_W | Number of payload bytes, sampled at start |
| gap_clks | input | GAP_W | Idle clocks between strobes, sampled at start |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken this cycle |
| init_n | input | 1 | Target init line; high means ready |
| done_i | input | 1 | Target done line |
| prog_n | output | 1 | Active-low program line to target |
| wr_data | output | 8 | Configuration byte |
| wr_stb | output | 1 | One-cycle write strobe for wr_data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded (sticky until next start) |
| error | output | 1 | Last load failed or timed out (sticky until next start) |

## Verification
Strobes are registered. A byte is therefore due on the clock after the cycle that issued it, and a payload byte is due on the clock after its handshake. The next strobe follows after exactly gap_clks more idle clocks. The outcome flags settle gap_clks plus one cycles after the last startup strobe, on the same edge where busy falls. The monitor samples on the falling edge. It pops each strobed byte from the expected queue and checks the spacing between strobes against the cycle counter. Status-line changes are driven from the monitor on the falling edge after a given strobe count, so the frame-boundary decision that follows sees them at a known edge.

// File: rtl/fpga_cfg_streamer.sv
module fpga_cfg_streamer #(
  parameter int HOLD_CLKS    = 500,
  parameter int INIT_TIMEOUT = 100000,
  parameter int LEN_W        = 16,
  parameter int GAP_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [GAP_W-1:0] gap_clks,
  input  logic [7:0]       pay_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic             init_n,
  input  logic             done_i,
  output logic             prog_n,
  output logic [7:0]       wr_data,
  output logic             wr_stb,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int TMR_MAX = (HOLD_CLKS > INIT_TIMEOUT) ? HOLD_CLKS : INIT_TIMEOUT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [5:0] PAY_FIRST = 6'd1;
  localparam logic [5:0] PAY_LAST  = 6'd21;
  localparam logic [5:0] FRM_LAST  = 6'd27;
  localparam logic [5:0] HDR_LAST  = 6'd7;
  localparam logic [5:0] TAIL_LAST = 6'd3;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WAIT, S_HDR, S_FRM, S_TAIL, S_FIN} st_t;

  st_t              st;
  logic [5:0]       pos;
  logic [LEN_W-1:0] rem;
  logic [GAP_W-1:0] gap_cnt, gap_q;
  logic [TMR_W-1:0] tmr;
  logic             issue;
  logic [7:0]       nbyte;

  function automatic logic [7:0] hdr_byte(input logic [5:0] p);
    case (p)
      6'd3:    return 8'h4F;
      6'd4:    return 8'h80;
      6'd5:    return 8'hAF;
      6'd6:    return 8'h9B;
      6'd7:    return 8'h4B;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] frm_fix(input logic [5:0] p);
    case (p)
      6'd0:    return 8'h4F;
      6'd22:   return 8'h4B;
      6'd24:   return 8'h4B;
      default: return 8'hFF;
    endcase
  endfunction

  wire slot    = (gap_cnt == '0);
  wire is_pay  = (st == S_FRM) && (pos >= PAY_FIRST) && (pos <= PAY_LAST);
  wire have    = (rem != '0);
  wire frm_ok  = init_n && !done_i && have;

  assign busy      = (st != S_IDLE);
  assign pay_ready = slot && is_pay && have;

  always_comb begin
    issue = 1'b0;
    nbyte = 8'hFF;
    case (st)
      S_HDR:  begin issue = slot; nbyte = hdr_byte(pos); end
      S_TAIL: issue = slot;
      S_FRM: begin
        issue = slot && (pos == '0 || !is_pay || !have || pay_valid);
        if (pos == '0)          nbyte = frm_ok ? 8'h4F : 8'hFF;
        else if (is_pay)        nbyte = have ? pay_data : 8'hFF;
        else                    nbyte = frm_fix(pos);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pos <= '0; rem <= '0; gap_cnt <= '0; gap_q <= '0; tmr <= '0;
      prog_n <= 1'b1; wr_stb <= 1'b0; wr_data <= '0; done <= 1'b0; error <= 1'b0;
    end else begin
      wr_stb <= issue;
      if (issue) begin
        wr_data <= nbyte;
        gap_cnt <= gap_q;
      end else if (!slot) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_PROG; prog_n <= 1'b0; tmr <= '0; pos <= '0;
          rem <= pay_len; gap_q <= gap_clks; gap_cnt <= '0;
          done <= 1'b0; error <= 1'b0;
        end
        S_PROG: if (tmr == TMR_W'(HOLD_CLKS - 1)) begin
          prog_n <= 1'b1; tmr <= '0; st <= S_WAIT;
        end else tmr <= tmr + 1'b1;
        S_WAIT: if (init_n) begin
          st <= S_HDR; pos <= '0;
        end else if (tmr == TMR_W'(INIT_TIMEOUT - 1)) begin
          error <= 1'b1; st <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        S_HDR: if (issue) begin
          if (pos == HDR_LAST) begin st <= S_FRM; pos <= '0; end
          else pos <= pos + 1'b1;
        end
        S_FRM: if (issue) begin
          if (pos == '0 && !frm_ok) begin
            st <= S_TAIL; pos <= 6'd1;
          end else begin
            if (is_pay && have) rem <= rem - 1'b1;
            pos <= (pos == FRM_LAST) ? '0 : pos + 1'b1;
          end
        end
        S_TAIL: if (issue) begin
          if (pos == TAIL_LAST) st <= S_FIN;
          else pos <= pos + 1'b1;
        end
        S_FIN: if (slot) begin
          st <= S_IDLE;
          if (done_i && !have) done <= 1'b1;
          else error <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_stb && prog_n));
  p_prog_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> !$past(busy));
  p_no_write_in_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !wr_stb);
  p_pay_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && pay_valid) |=> (wr_stb && wr_data == $past(pay_data)));
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_strobe_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && gap_q != '0) |=> !wr_stb);
endmodule

// File: tb/fpga_cfg_streamer_tb.sv
module fpga_cfg_streamer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;
  localparam int TMO  = 40;

  logic clk = 0, rst_n = 0, start = 0, pay_valid = 1, init_n = 0, done_i = 0;
  logic [15:0] pay_len = 0;
  logic [3:0]  gap_clks = 0;
  logic [7:0]  pay_data, wr_data;
  logic pay_ready, prog_n, wr_stb, busy, done, error;

  int checks = 0, errors = 0, cyc = 0;
  int hs_cnt = 0, base_idx = 0;
  int run_stb = 0, last_cyc = -1, gap_exp = 0, done_at = 0, drop_at = 0;
  int prog_low = 0, stb_total = 0;
  logic [7:0] exp_q[$];

  fpga_cfg_streamer #(.HOLD_CLKS(HOLD), .INIT_TIMEOUT(TMO), .LEN_W(16), .GAP_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len), .gap_clks(gap_clks),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .init_n(init_n), .done_i(done_i), .prog_n(prog_n), .wr_data(wr_data),
    .wr_stb(wr_stb), .busy(busy), .done(done), .error(error));

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign pay_data = pat(hs_cnt - base_idx);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pay_ready && pay_valid) hs_cnt <= hs_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !prog_n) prog_low++;
    if (rst_n && wr_stb) begin
      stb_total++;
      run_stb++;
      if (exp_q.size() == 0) check(0, "R5 unexpected strobe", wr_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(wr_data == e, "R4/R5/R6/R8 byte", wr_data, e);
      end
      if (last_cyc >= 0) check(cyc - last_cyc == gap_exp + 1, "R11 spacing", cyc - last_cyc, gap_exp + 1);
      last_cyc = cyc;
      if (done_at > 0 && run_stb == done_at) done_i = 1;
      if (drop_at > 0 && run_stb == drop_at) init_n = 0;
    end
  end

  task automatic run(input int len, input int gap, input int frames, input int d_at,
                     input int x_at, input bit exp_done, input bit restart);
    exp_q = {8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    for (int f = 0; f < frames; f++) begin
      exp_q.push_back(8'h4F);
      for (int k = 0; k < 21; k++)
        exp_q.push_back((f * 21 + k < len) ? pat(f * 21 + k) : 8'hFF);
      exp_q.push_back(8'h4B); exp_q.push_back(8'hFF); exp_q.push_back(8'h4B);
      exp_q.push_back(8'hFF); exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
    end
    for (int t = 0; t < 4; t++) exp_q.push_back(8'hFF);
    @(negedge clk);
    pay_len = 16'(len); gap_clks = 4'(gap); base_idx = hs_cnt;
    run_stb = 0; last_cyc = -1; gap_exp = gap; done_at = d_at; drop_at = x_at;
    done_i = 0; init_n = 0; prog_low = 0;
    start = 1; @(negedge clk); start = 0;
    while (!prog_n) @(negedge clk);
    check(prog_low == HOLD, "R2 program hold", prog_low, HOLD);
    repeat (6) @(negedge clk);
    check(run_stb == 0, "R3 no write before init", run_stb, 0);
    init_n = 1;
    if (restart) begin
      repeat (12) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      check(prog_n == 1'b1, "R12 start while busy", prog_n, 1);
    end
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R5/R7/R8 stream length", exp_q.size(), 0);
    check(done == exp_done, "R9 done flag", done, exp_done);
    check(error == !exp_done, "R9 error flag", error, !exp_done);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(prog_n == 1 && wr_stb == 0, "R1 reset lines", {prog_n, wr_stb}, 2);
    check(!busy && !done && !error, "R1 reset flags", {busy, done, error}, 0);
    rst_n = 1;
    @(negedge clk);
    run(42, 0, 2, 64, 0, 1, 1);   // R4 R5 R8 R9 R12
    run(25, 2, 2, 64, 0, 1, 0);   // R6 R11
    run(63, 3, 1, 36, 0, 0, 0);   // R7 done early
    run(42, 1, 1, 0, 36, 0, 0);   // R7 init drop
    run(0, 0, 0, 8, 0, 1, 0);     // R7 R8 empty payload
    // R10 init timeout
    @(negedge clk);
    init_n = 0; done_i = 0; gap_clks = 0; pay_len = 21;
    begin
      int s0, c0;
      s0 = stb_total; c0 = cyc;
      start = 1; @(negedge clk); start = 0;
      while (busy) @(negedge clk);
      check(error == 1 && done == 0, "R10 timeout error", error, 1);
      check(stb_total == s0, "R10 no bytes", stb_total - s0, 0);
      check(cyc - c0 >= HOLD + TMO, "R10 timeout length", cyc - c0, HOLD + TMO);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule